// File: doc/BRIEF.md
# Two-Bit Loop Pattern Recorder

This block is a tiny step sequencer that loops over an eight-entry memory of 2-bit patterns. A prescaler makes a one-cycle tick every `TICK_DIV` clocks, and each tick moves a step pointer to the next entry. After the last entry the pointer returns to entry 0, and this repeats for as long as the block runs. The entry under the pointer is read from an inferred synchronous RAM. Its value drives two LED outputs through the RAM's registered read port.

Two pattern buttons set a live 2-bit value, one bit per button. A record button stores that value into the entry being played at that moment. This lets the user edit the loop while it runs. Every button is first synchronised into the clock domain, then filtered so that a new level is taken only after it has held for `DEB_CYCLES` clocks.

After reset the block walks the RAM once and writes zero to every entry. The pointer stays at step 0 during this walk. Because all entries start at zero, the LEDs stay dark until a pattern is recorded.

Top module: `loop_pattern_recorder`

## Requirements
- R1: While reset is asserted, and during the clearing walk that follows it, `step_o` is 0 and `led_o` is 2'b00; after any reset, every entry reads back as 2'b00 on its next visit.
- R2: Outside the clearing walk, `step_o` changes exactly once every `TICK_DIV` clock cycles.
- R3: Each change of `step_o` adds one to it, except that a change from `DEPTH-1` goes to 0.
- R4: `led_o` changes only on the clock edge right after a `step_o` change, and then shows the entry at the new `step_o`; it holds that value until the next such edge.
- R5: A record press writes `{btn_hi_i, btn_lo_i}` into the entry at the current step (`btn_hi_i` gives bit 1, `btn_lo_i` gives bit 0), and that value appears on `led_o` on the next visit to that step.
- R6: A write to the entry being played does not alter `led_o` while that step is still current; `led_o` keeps showing the old value until the pointer moves on.
- R7: Holding the record button down through several steps writes only the entry at the step where the filtered press began; all other entries keep their values.
- R8: A button level that lasts fewer than `DEB_CYCLES` clock cycles has no effect, so a short record pulse writes nothing.
- R9: After reset is released, the clearing walk lasts `DEPTH` cycles; the first step change comes `DEPTH + TICK_DIV` clock edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_lo_i | input | 1 | Raw pattern button for bit 0 |
| btn_hi_i | input | 1 | Raw pattern button for bit 1 |
| btn_rec_i | input | 1 | Raw record button |
| led_o | output | 2 | Pattern of the current step, registered |
| step_o | output | 3 | Current step index |

## Verification
On every cycle, the assertions check the following: the pointer only moves forward by one and wraps at the end; the prescaler tick lasts a single cycle; the LEDs stay dark and the pointer stays at zero during the clearing walk; the LEDs change only right after a pointer move; a filtered button level changes only after a full qualifying count; and one filtered press gives at most one write. The bench scenarios cover what needs the stored contents: which entry a press lands in, that a write hides until the next visit, that a long hold writes only one entry, that a short pulse writes nothing, and that a second reset wipes recorded entries. They also measure the exact tick period and the delay of the first step change after reset.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic {
    LPR_WIPE = 1'b0,
    LPR_PLAY = 1'b1
  } lpr_mode_e;
endpackage

// File: rtl/lpr_btn_filter.sv
module lpr_btn_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          meta_q;
  logic          sync_q;
  logic          level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (sync_q == level_q) begin
        run_q <= '0;
      end else if (run_q == CW'(DEB_CYCLES - 1)) begin
        level_q <= sync_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;

  // R8
  deb_qualify_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(run_q) == CW'(DEB_CYCLES - 1)));
endmodule

// File: rtl/lpr_tick_gen.sv
module lpr_tick_gen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] div_q;

  assign tick_o = !hold_i && (div_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || hold_i || tick_o) div_q <= '0;
    else                         div_q <= div_q + 1'b1;
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lpr_step_ram.sv
module lpr_step_ram #(
  parameter int DEPTH = 8,
  parameter int PAT_W = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PAT_W-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [PAT_W-1:0] rdata_o
);
  logic [PAT_W-1:0] cells [DEPTH];
  logic [PAT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (re_i) rd_q <= cells[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/loop_pattern_recorder.sv
module loop_pattern_recorder
  import lpr_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int PAT_W      = 2,
  parameter int TICK_DIV   = 16,
  parameter int DEB_CYCLES = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_lo_i,
  input  logic             btn_hi_i,
  input  logic             btn_rec_i,
  output logic [PAT_W-1:0] led_o,
  output logic [AW-1:0]    step_o
);
  localparam int NBTN = 3;

  logic [NBTN-1:0] raw_btn;
  logic [NBTN-1:0] clean_btn;

  assign raw_btn = {btn_rec_i, btn_hi_i, btn_lo_i};

  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    lpr_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_btn[g]),
      .level_o(clean_btn[g])
    );
  end

  lpr_mode_e        mode_q;
  logic [AW-1:0]    wipe_addr_q;
  logic [AW-1:0]    step_q;
  logic             fresh_q;
  logic             rec_prev_q;
  logic             wiping;
  logic             tick;
  logic             rec_rise;
  logic             rec_wr;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [PAT_W-1:0] ram_wdata;
  logic [PAT_W-1:0] live_pat;

  assign wiping   = (mode_q == LPR_WIPE);
  assign live_pat = PAT_W'({clean_btn[1], clean_btn[0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= LPR_WIPE;
      wipe_addr_q <= '0;
    end else if (wiping) begin
      wipe_addr_q <= wipe_addr_q + 1'b1;
      if (wipe_addr_q == AW'(DEPTH - 1)) mode_q <= LPR_PLAY;
    end
  end

  lpr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .hold_i(wiping),
    .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick;
      if (tick) step_q <= (step_q == AW'(DEPTH - 1)) ? '0 : step_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_prev_q <= 1'b0;
    else     rec_prev_q <= clean_btn[2];
  end

  assign rec_rise  = clean_btn[2] && !rec_prev_q;
  assign rec_wr    = rec_rise && !wiping;
  assign ram_we    = wiping || rec_wr;
  assign ram_waddr = wiping ? wipe_addr_q : step_q;
  assign ram_wdata = wiping ? '0 : live_pat;

  lpr_step_ram #(.DEPTH(DEPTH), .PAT_W(PAT_W)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .re_i   (fresh_q),
    .raddr_i(step_q),
    .rdata_o(led_o)
  );

  assign step_o = step_q;

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q != $past(step_q)) |->
      (step_q == (($past(step_q) == AW'(DEPTH - 1)) ? AW'(0) : AW'($past(step_q) + 1'b1))));

  // R1
  wipe_dark_chk: assert property (@(posedge clk) disable iff (rst)
    wiping |-> (led_o == '0 && step_q == '0));

  // R4
  led_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (led_o != $past(led_o)) |-> $past(fresh_q));

  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    rec_wr |=> !rec_wr);
endmodule

// File: tb/loop_pattern_recorder_tb.sv
`timescale 1ns/1ps
module loop_pattern_recorder_tb;
  localparam int DEPTH = 8;
  localparam int TDIV  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       b_lo = 1'b0;
  logic       b_hi = 1'b0;
  logic       b_rec = 1'b0;
  logic [1:0] led;
  logic [2:0] step;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_mem [DEPTH];

  always #2.5 clk = ~clk;

  loop_pattern_recorder u_dut (
    .clk(clk), .rst(rst), .btn_lo_i(b_lo), .btn_hi_i(b_hi),
    .btn_rec_i(b_rec), .led_o(led), .step_o(step)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_change(output int cyc, output int prev);
    prev = step;
    cyc  = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (step == prev);
  endtask

  task automatic t_reset();
    int cnt;
    bit dark;
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(step == 0, "R1 step in reset", step, 0);
    chk(led == 0, "R1 led in reset", led, 0);
    rst = 1'b0;
    cnt = 0;
    dark = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      if (led != 0) dark = 1'b0;
    end while (step == 0 && cnt < 100);
    chk(cnt == DEPTH + TDIV, "R9 first step delay", cnt, DEPTH + TDIV);
    chk(dark, "R1 dark after reset", led, 0);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 2'b00;
  endtask

  task automatic t_timing();
    int cyc, prev;
    wait_change(cyc, prev);
    for (int i = 0; i < DEPTH + 2; i++) begin
      wait_change(cyc, prev);
      chk(cyc == TDIV, "R2 step period", cyc, TDIV);
      chk(step == ((prev == DEPTH - 1) ? 0 : prev + 1), "R3 step order", step,
          (prev == DEPTH - 1) ? 0 : prev + 1);
    end
  endtask

  task automatic verify_loop(input string tag);
    int cyc, prev;
    for (int i = 0; i < DEPTH; i++) begin
      wait_change(cyc, prev);
      chk(led == exp_mem[prev], "R4 led held until next edge", led, exp_mem[prev]);
      @(negedge clk);
      chk(led == exp_mem[step], tag, led, exp_mem[step]);
    end
  endtask

  task automatic set_pat(input logic [1:0] p);
    int cyc, prev;
    b_hi = p[1];
    b_lo = p[0];
    wait_change(cyc, prev);
  endtask

  task automatic t_record(input logic [1:0] p);
    int cyc, prev, target;
    logic [1:0] old;
    set_pat(p);
    wait_change(cyc, prev);
    @(negedge clk);
    target = step;
    old = exp_mem[target];
    b_rec = 1'b1;
    repeat (10) @(negedge clk);
    b_rec = 1'b0;
    chk(led == old, "R6 led unchanged within step", led, old);
    wait_change(cyc, prev);
    chk(led == old, "R6 old value until step leaves", led, old);
    exp_mem[target] = p;
    verify_loop("R5 recorded entry shown");
  endtask

  task automatic t_long_hold(input logic [1:0] p);
    int cyc, prev, target;
    set_pat(p);
    wait_change(cyc, prev);
    @(negedge clk);
    target = step;
    b_rec = 1'b1;
    repeat (4 * TDIV) @(negedge clk);
    b_rec = 1'b0;
    exp_mem[target] = p;
    wait_change(cyc, prev);
    verify_loop("R7 only first step written");
  endtask

  task automatic t_glitch(input logic [1:0] p);
    int cyc, prev;
    set_pat(p);
    for (int k = 0; k < 4; k++) begin
      wait_change(cyc, prev);
      @(negedge clk);
      b_rec = 1'b1;
      repeat (2) @(negedge clk);
      b_rec = 1'b0;
    end
    verify_loop("R8 short pulse ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1..R9 actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    verify_loop("R1 entries cleared");
    t_timing();
    t_record(2'b01);
    t_record(2'b10);
    t_long_hold(2'b11);
    t_glitch(2'b01);
    t_reset();
    verify_loop("R1 entries cleared by second reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule